// File: doc/BRIEF.md
# Dual-Module Residue Arbitration Unit

This unit decides, sample by sample, which result to trust when a filter runs as two identical copies beside a small checking branch. The checking branch computes the filter result modulo a small constant `MOD` and delivers only that residue. The unit takes the two full-width results and the residue. It forms each result's own residue, compares everything, and registers a chosen output sample. On the same clock it raises one of several single-cycle indications: a repair request for copy one, a repair request for copy two, a repair request for the checking branch, a flag for a mismatch that the residue cannot place, or a flag for a failure in more than one branch.

The residue does two jobs. When the two copies agree, it tests the checking branch itself. When the two copies disagree, it picks the copy that is consistent with it. The way the residue is reduced depends on `MOD`. A power of two takes the low bits. A modulus of the form 2^n-1 uses end-around folding of n-bit chunks. Any other modulus uses a general remainder. Repair of a flagged branch is done by logic outside this unit, which acts on the requests.

Top module: `dm_residue_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `out_valid`, `y_out` and all five indication outputs are 0.
- R2: Every input sample with `in_valid` high produces exactly one output sample with `out_valid` high on the next rising clock edge. With `in_valid` low, the next cycle has `out_valid` and all indications at 0, and `y_out` keeps its previous value.
- R3: If `y1` equals `y2` and (`y1` mod `MOD`) equals `r`, then `y_out` = `y1` and no indication is raised.
- R4: If `y1` equals `y2` but (`y1` mod `MOD`) differs from `r`, then `y_out` = `y1` and `rec_chk` pulses.
- R5: If `y1` differs from `y2`, and only `y1` has a residue equal to `r`, then `y_out` = `y1` and `rec_mod2` pulses.
- R6: If `y1` differs from `y2`, and only `y2` has a residue equal to `r`, then `y_out` = `y2` and `rec_mod1` pulses.
- R7: If `y1` differs from `y2` and both residues equal `r`, then `y_out` = `y1`, `congruent` pulses and no repair request is raised.
- R8: If `y1` differs from `y2` and neither residue equals `r`, then `y_out` = `y1`, `multi_fail` pulses and no repair request is raised.
- R9: In any cycle at most one of `rec_mod1`, `rec_mod2`, `rec_chk`, `congruent` and `multi_fail` is high, and only while `out_valid` is high.
- R10: An `r` value of `MOD` or above matches no result residue. It is handled as a residue mismatch; for example, agreeing copies with `r` = `MOD` raise `rec_chk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present on `y1`, `y2` and `r` |
| y1 | input | DATA_W | Result from filter copy one |
| y2 | input | DATA_W | Result from filter copy two |
| r | input | RES_W | Residue from the checking branch |
| out_valid | output | 1 | Registered sample valid |
| y_out | output | DATA_W | Chosen result |
| rec_mod1 | output | 1 | Pulse: repair copy one |
| rec_mod2 | output | 1 | Pulse: repair copy two |
| rec_chk | output | 1 | Pulse: repair the checking branch |
| congruent | output | 1 | Pulse: mismatch that the residue cannot locate |
| multi_fail | output | 1 | Pulse: more than one branch inconsistent |

## Verification
Output selection and the repair request always fall in the same registered cycle. The most telling case is a sample where copy two wins, so `y_out` must carry `y2` while `rec_mod1` is high. Samples of every class are sent back to back, so each pulse has to clear exactly when the next verdict replaces it. One output cycle is judged on the value and the indication bits together. An idle cycle placed after a pulse shows that the indication drops and that `y_out` holds its value.

// File: rtl/dm_arb_pkg.sv
package dm_arb_pkg;

   // Outcome of comparing two module results and the checker residue
   typedef enum logic [2:0] {
      VERD_CLEAN     = 3'd0,
      VERD_CHK_BAD   = 3'd1,
      VERD_KEEP1     = 3'd2,
      VERD_KEEP2     = 3'd3,
      VERD_CONGRUENT = 3'd4,
      VERD_MULTI     = 3'd5
   } verdict_e;

   // Registered indication bundle
   typedef struct packed {
      logic multi_fail;
      logic congruent;
      logic rec_chk;
      logic rec_mod2;
      logic rec_mod1;
   } arb_flags_t;

   // Residue reduction variants chosen from the modulus
   typedef enum logic [1:0] {
      RED_SLICE = 2'd0,
      RED_FOLD  = 2'd1,
      RED_DIV   = 2'd2
   } reduce_kind_e;

   function automatic reduce_kind_e pick_reduce(input int modv);
      if ((modv & (modv - 1)) == 0)
         return RED_SLICE;
      else if (((modv + 1) & modv) == 0)
         return RED_FOLD;
      else
         return RED_DIV;
   endfunction

endpackage

// File: rtl/dm_residue_reduce.sv
module dm_residue_reduce
   import dm_arb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int MOD    = 7,
   parameter int RES_W  = $clog2(MOD)
) (
   input  logic [DATA_W-1:0] value,
   output logic [RES_W-1:0]  residue
);

   localparam reduce_kind_e KIND   = pick_reduce(MOD);
   localparam int           CHUNKS = (DATA_W + RES_W - 1) / RES_W;
   localparam int           PAD_W  = CHUNKS * RES_W;
   localparam int           ACC_W  = RES_W + $clog2(CHUNKS + 1) + 1;

   if (MOD < 2) begin : g_bad_mod
      $error("dm_residue_reduce: MOD must be at least 2");
   end
   if (DATA_W < RES_W) begin : g_bad_width
      $error("dm_residue_reduce: DATA_W must cover the residue width");
   end

   if (KIND == RED_SLICE) begin : g_slice
      // Power-of-two modulus: the residue is the low bits
      logic unused_hi;
      assign unused_hi = ^value;
      assign residue   = value[RES_W-1:0];
   end else if (KIND == RED_FOLD) begin : g_fold
      // 2^n-1 modulus: sum n-bit chunks, fold carries back, map MOD to 0
      logic [PAD_W-1:0] padded;
      logic [ACC_W-1:0] acc;
      assign padded = PAD_W'(value);
      always_comb begin
         acc = '0;
         for (int c = 0; c < CHUNKS; c++) begin
            acc = acc + ACC_W'(padded[c*RES_W +: RES_W]);
         end
         for (int f = 0; f < ACC_W; f++) begin
            acc = ACC_W'(acc[RES_W-1:0]) + (acc >> RES_W);
         end
         if (acc[RES_W-1:0] == RES_W'(MOD))
            residue = '0;
         else
            residue = acc[RES_W-1:0];
      end
   end else begin : g_div
      // Any other modulus: general remainder
      logic [DATA_W-1:0] rem;
      assign rem     = value % DATA_W'(MOD);
      assign residue = rem[RES_W-1:0];
      logic unused_rem;
      assign unused_rem = ^rem;
   end

endmodule

// File: rtl/dm_verdict_decode.sv
module dm_verdict_decode
   import dm_arb_pkg::*;
(
   input  logic     same,
   input  logic     m1_ok,
   input  logic     m2_ok,
   output verdict_e verdict,
   output logic     take_y2
);

   always_comb begin
      if (same) begin
         // Both copies agree: the residue judges the checker
         verdict = m1_ok ? VERD_CLEAN : VERD_CHK_BAD;
      end else begin
         unique case ({m1_ok, m2_ok})
            2'b10:   verdict = VERD_KEEP1;
            2'b01:   verdict = VERD_KEEP2;
            2'b11:   verdict = VERD_CONGRUENT;
            default: verdict = VERD_MULTI;
         endcase
      end
      take_y2 = (verdict == VERD_KEEP2);
   end

endmodule

// File: rtl/dm_residue_arbiter.sv
module dm_residue_arbiter
   import dm_arb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int MOD    = 7,
   parameter int RES_W  = $clog2(MOD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] y1,
   input  logic [DATA_W-1:0] y2,
   input  logic [RES_W-1:0]  r,
   output logic              out_valid,
   output logic [DATA_W-1:0] y_out,
   output logic              rec_mod1,
   output logic              rec_mod2,
   output logic              rec_chk,
   output logic              congruent,
   output logic              multi_fail
);

   localparam int BRANCHES = 2;

   if (RES_W < $clog2(MOD)) begin : g_bad_res
      $error("dm_residue_arbiter: RES_W too narrow for MOD");
   end

   logic [DATA_W-1:0] branch_val [BRANCHES];
   logic [RES_W-1:0]  branch_res [BRANCHES];
   logic [BRANCHES-1:0] branch_ok;

   assign branch_val[0] = y1;
   assign branch_val[1] = y2;

   for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
      dm_residue_reduce #(
         .DATA_W (DATA_W),
         .MOD    (MOD),
         .RES_W  (RES_W)
      ) u_reduce (
         .value   (branch_val[b]),
         .residue (branch_res[b])
      );
      assign branch_ok[b] = (branch_res[b] == r);
   end

   verdict_e verdict;
   logic     take_y2;

   dm_verdict_decode u_decode (
      .same    (y1 == y2),
      .m1_ok   (branch_ok[0]),
      .m2_ok   (branch_ok[1]),
      .verdict (verdict),
      .take_y2 (take_y2)
   );

   arb_flags_t flags_d, flags_q;

   always_comb begin
      flags_d = '0;
      if (in_valid) begin
         unique case (verdict)
            VERD_CHK_BAD:   flags_d.rec_chk    = 1'b1;
            VERD_KEEP1:     flags_d.rec_mod2   = 1'b1;
            VERD_KEEP2:     flags_d.rec_mod1   = 1'b1;
            VERD_CONGRUENT: flags_d.congruent  = 1'b1;
            VERD_MULTI:     flags_d.multi_fail = 1'b1;
            default:        flags_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         y_out     <= '0;
         flags_q   <= '0;
      end else begin
         out_valid <= in_valid;
         flags_q   <= flags_d;
         if (in_valid)
            y_out <= take_y2 ? y2 : y1;
      end
   end

   assign rec_mod1   = flags_q.rec_mod1;
   assign rec_mod2   = flags_q.rec_mod2;
   assign rec_chk    = flags_q.rec_chk;
   assign congruent  = flags_q.congruent;
   assign multi_fail = flags_q.multi_fail;

endmodule

// File: rtl/dm_residue_arbiter_chk.sv
module dm_residue_arbiter_chk #(
   parameter int DATA_W = 16,
   parameter int RES_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] y1,
   input logic [DATA_W-1:0] y2,
   input logic              out_valid,
   input logic [DATA_W-1:0] y_out,
   input logic              rec_mod1,
   input logic              rec_mod2,
   input logic              rec_chk,
   input logic              congruent,
   input logic              multi_fail
);

   logic [4:0] ind;
   assign ind = {multi_fail, congruent, rec_chk, rec_mod2, rec_mod1};

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && ind == 5'b0 && $stable(y_out)));

   // R9
   ind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ind));

   // R9
   ind_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ind != 5'b0) |-> out_valid);

   // R3
   agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && y1 == y2) |=> (y_out == $past(y1) && !rec_mod1 && !rec_mod2
                                  && !congruent && !multi_fail));

   // R4
   differ_no_chk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && y1 != y2) |=> !rec_chk);

   // R6
   keep2_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && y1 != y2) |=> (rec_mod1 ? (y_out == $past(y2)) : (y_out == $past(y1))));

endmodule

bind dm_residue_arbiter dm_residue_arbiter_chk #(
   .DATA_W (DATA_W),
   .RES_W  (RES_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .y1         (y1),
   .y2         (y2),
   .out_valid  (out_valid),
   .y_out      (y_out),
   .rec_mod1   (rec_mod1),
   .rec_mod2   (rec_mod2),
   .rec_chk    (rec_chk),
   .congruent  (congruent),
   .multi_fail (multi_fail)
);

// File: tb/dm_residue_arbiter_test.sv
module dm_residue_arbiter_test;

   localparam int DW = 16;
   localparam int M  = 7;
   localparam int RW = 3;
   localparam int NV = 11;

   // Indication order: {multi_fail, congruent, rec_chk, rec_mod2, rec_mod1}
   localparam logic [DW-1:0] T_Y1 [NV] = '{16'd100, 16'd100, 16'd50, 16'd50, 16'd10,
                                           16'd10, 16'd65535, 16'd0, 16'd0, 16'd14, 16'd65535};
   localparam logic [DW-1:0] T_Y2 [NV] = '{16'd100, 16'd100, 16'd51, 16'd51, 16'd17,
                                           16'd11, 16'd65535, 16'd0, 16'd7, 16'd14, 16'd65534};
   localparam logic [RW-1:0] T_R  [NV] = '{3'd2, 3'd5, 3'd1, 3'd2, 3'd3,
                                           3'd6, 3'd1, 3'd0, 3'd0, 3'd7, 3'd0};
   localparam logic [DW-1:0] T_YO [NV] = '{16'd100, 16'd100, 16'd50, 16'd51, 16'd10,
                                           16'd10, 16'd65535, 16'd0, 16'd0, 16'd14, 16'd65534};
   localparam logic [4:0]    T_F  [NV] = '{5'b00000, 5'b00100, 5'b00010, 5'b00001, 5'b01000,
                                           5'b10000, 5'b00000, 5'b00000, 5'b01000, 5'b00100, 5'b00001};
   localparam string         T_REQ [NV] = '{"R3", "R4", "R5", "R6", "R7",
                                            "R8", "R3", "R3", "R7", "R10", "R6"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] y1 = '0, y2 = '0;
   logic [RW-1:0] r = '0;
   logic          out_valid;
   logic [DW-1:0] y_out;
   logic          rec_mod1, rec_mod2, rec_chk, congruent, multi_fail;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dm_residue_arbiter #(.DATA_W(DW), .MOD(M), .RES_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y1(y1), .y2(y2), .r(r),
      .out_valid(out_valid), .y_out(y_out), .rec_mod1(rec_mod1), .rec_mod2(rec_mod2),
      .rec_chk(rec_chk), .congruent(congruent), .multi_fail(multi_fail));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] ind();
      return {multi_fail, congruent, rec_chk, rec_mod2, rec_mod1};
   endfunction

   task automatic drive(input logic v, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [RW-1:0] rr);
      in_valid = v; y1 = a; y2 = b; r = rr;
   endtask

   initial begin
      // R1: reset with a sample present
      @(negedge clk);
      drive(1'b1, 16'd9, 16'd3, 3'd6);
      @(negedge clk);
      check("R1 valid", 32'(out_valid), 32'd0);
      check("R1 y_out", 32'(y_out), 32'd0);
      check("R1 ind", 32'(ind()), 32'd0);
      drive(1'b0, '0, '0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 32'({out_valid, ind()}), 32'd0);

      // Table walk, samples back to back
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, T_Y1[i], T_Y2[i], T_R[i]);
         @(negedge clk);
         check({T_REQ[i], " R2 valid"}, 32'(out_valid), 32'd1);
         check({T_REQ[i], " y_out"}, 32'(y_out), 32'(T_YO[i]));
         check({T_REQ[i], " R9 ind"}, 32'(ind()), 32'(T_F[i]));
      end

      // R2 / R9: idle after a pulse; the pulse clears, y_out holds
      drive(1'b0, 16'd1, 16'd2, 3'd3);
      @(negedge clk);
      check("R2 idle valid", 32'(out_valid), 32'd0);
      check("R9 idle ind", 32'(ind()), 32'd0);
      check("R2 idle hold", 32'(y_out), 32'd65534);

      // R6 then R5 directly adjacent, selection and request in the same cycle
      drive(1'b1, 16'd700, 16'd701, 3'd1);   // 700 mod 7 = 0, 701 mod 7 = 1
      @(negedge clk);
      check("R6 y2 chosen", 32'(y_out), 32'd701);
      check("R6 rec_mod1", 32'(ind()), 32'b00001);
      drive(1'b1, 16'd700, 16'd701, 3'd0);
      @(negedge clk);
      check("R5 y1 chosen", 32'(y_out), 32'd700);
      check("R5 rec_mod2", 32'(ind()), 32'b00010);

      // R10: residue value equal to MOD with agreeing copies at residue 0
      drive(1'b1, 16'd49, 16'd49, 3'd7);
      @(negedge clk);
      check("R10 rec_chk", 32'(ind()), 32'b00100);

      // R1: reset mid-stream clears outputs
      drive(1'b1, 16'd5, 16'd6, 3'd0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset", 32'({out_valid, ind(), y_out}), 32'd0);
      rst_n = 1'b1;
      drive(1'b0, '0, '0, '0);
      @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule